// File: doc/BRIEF.md
# Debug Run-Control Register Unit

This unit is the run-control front end of a debug module serving up to eight processor harts. A debugger reaches it through a simple register port: a 7-bit address, a write strobe, a read strobe and 32-bit data. Two registers are implemented. The control register sits at address 0x10 and the status register at address 0x11. Every other address reads as zero. The register port has no back-pressure. A write is taken on the clock edge where `reg_wr` is high. A read is combinational and valid in the same cycle as `reg_rd`. Nothing is queued, so the port is always ready.

Through the control register the debugger selects a group of harts. It can ask the selected harts to halt or to resume, hold them in reset, reset the whole system apart from the debug logic, and acknowledge have-reset events. The unit turns these register values into per-hart request levels. A resume request stays asserted for each hart until that hart reports that it has resumed. The status register summarises the per-hart halted, running, unavailable, resume-acknowledged and have-reset conditions over the selected harts as "any" and "all" flags. It also flags a selection that names a hart which is not implemented.

The hart-array mask that widens the selection comes in on a port from the surrounding debug logic.

Top module: `dbg_runctl`

## Requirements
- R1: After reset all request outputs are low and the control register reads 0. Every implemented hart starts with its have-reset flag set, so status bits 19 and 18 read 1 for any selected implemented hart.
- R2: The status register returns 2 in bits 3:0, 1 in bit 7 (access is always granted) and 0 in bit 22 (no automatic breakpoint after the program buffer). Its unused bits read 0. Unmapped addresses read 0, and every read with `reg_rd` low returns 0.
- R3: While the active bit (control bit 0) is 0, a control write changes only that bit. All other fields stay 0. A write with bit 0 equal to 0 clears every field and every pending resume request from the next cycle on.
- R4: The hart-select field occupies control bits 25:16 and the array-select bit is bit 26. With bit 26 at 0, only hart `sel` is addressed. With bit 26 at 1, each hart whose `hart_mask_i` bit is set is addressed as well. The halt request is bit 31. In the cycle after the write, `halt_req_o` is high for exactly the addressed harts.
- R5: Hart reset is bit 29 and drives `hart_reset_o` for the addressed harts. System reset is bit 1 and drives `sys_reset_o`. Both take effect in the cycle after the write.
- R6: A write with bit 30 at 1 and bit 31 at 0 clears the resume-acknowledged flag of each hart addressed by that write, and sets that hart's `resume_req_o`. A high `resume_ack_i` on a hart with a pending request drops the request and sets its flag from the next cycle. A write with both bit 30 and bit 31 at 1 starts no resume.
- R7: When a resume write and a `resume_ack_i` for the same hart land in the same cycle, the write wins. The request stays high and the flag stays 0.
- R8: Status bits 9 and 8 give all-halted and any-halted. Bits 11 and 10 give all-running and any-running. Bits 13 and 12 give all-unavailable and any-unavailable, where a hart counts as unavailable while its reset or the system reset is driven. Bits 17 and 16 give all-resume-acknowledged and any-resume-acknowledged. All of these are taken over the addressed implemented harts, and an "all" flag is 0 when no implemented hart is addressed.
- R9: Status bits 15 and 14 both read 1 when the hart-select field is at least the implemented hart count, and both read 0 otherwise.
- R10: A hart's have-reset flag is set in the cycle after its reset (hart or system) deasserts. Status bits 19 and 18 report the all and any summaries of this flag. A control write with bit 28 at 1 clears the flag for the harts addressed by that write. If a set and a clear land in the same cycle, the set wins.
- R11: The control register reads back bits 31, 29, 26, 25:16, 1 and 0 as stored. Bits 30 and 28 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 7 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| hart_mask_i | input | NUM_HARTS | Extra harts addressed when array select is set |
| halted_i | input | NUM_HARTS | Per-hart halted level |
| running_i | input | NUM_HARTS | Per-hart running level |
| resume_ack_i | input | NUM_HARTS | Per-hart resumed indication |
| halt_req_o | output | NUM_HARTS | Per-hart halt request |
| resume_req_o | output | NUM_HARTS | Per-hart pending resume request |
| hart_reset_o | output | NUM_HARTS | Per-hart reset |
| sys_reset_o | output | 1 | System reset |

## Verification
Two pairs of events can fall on the same edge. In the first, a resume write meets a resume acknowledgement from the same hart. The bench provokes it by raising `resume_ack_i` for a hart that already has a pending request, in the very cycle it issues a second resume write to that hart. It then expects the request to stay high and the acknowledged flag to read 0. In the second, a have-reset set meets its clear. The bench releases a hart reset and then issues the acknowledge write on the next cycle, which is the edge where the release is detected. It expects the have-reset flag to survive. A behavioural model compares every output and the status and control read data on every cycle, including these two cases.

// File: rtl/dbg_runctl_pkg.sv
package dbg_runctl_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 32;
  localparam int SEL_W  = 10;
  localparam int NFLAG  = 5;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 7'h10;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 7'h11;

  // control field positions
  localparam int C_ACTIVE = 0;
  localparam int C_SYSRST = 1;
  localparam int C_SEL_LO = 16;
  localparam int C_HASEL  = 26;
  localparam int C_ACKHR  = 28;
  localparam int C_HRST   = 29;
  localparam int C_RESUME = 30;
  localparam int C_HALT   = 31;

  // flag order inside the aggregation array
  localparam int F_HALTED = 0;
  localparam int F_RUN    = 1;
  localparam int F_UNAV   = 2;
  localparam int F_RACK   = 3;
  localparam int F_HRST   = 4;

  localparam logic [3:0] SPEC_VER = 4'd2;

  typedef struct packed {
    logic             halt;
    logic             hrst;
    logic             hasel;
    logic [SEL_W-1:0] hsel;
    logic             sysrst;
  } ctl_t;
endpackage

// File: rtl/dbg_hart_sel.sv
module dbg_hart_sel
  import dbg_runctl_pkg::*;
#(
  parameter int NUM_HARTS = 4
) (
  input  logic [SEL_W-1:0]     hartsel,
  input  logic                 hasel,
  input  logic [NUM_HARTS-1:0] mask,
  output logic [NUM_HARTS-1:0] sel,
  output logic                 beyond
);
  assign beyond = (int'(hartsel) >= NUM_HARTS);

  for (genvar i = 0; i < NUM_HARTS; i++) begin : g_sel
    assign sel[i] = (hartsel == SEL_W'(i)) | (hasel & mask[i]);
  end
endmodule

// File: rtl/dbg_hart_track.sv
module dbg_hart_track #(
  parameter int NUM_HARTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 resume_wr,
  input  logic                 ackhr_wr,
  input  logic                 deact,
  input  logic [NUM_HARTS-1:0] wr_sel,
  input  logic [NUM_HARTS-1:0] eff_rst,
  input  logic [NUM_HARTS-1:0] resume_ack_i,
  output logic [NUM_HARTS-1:0] pending,
  output logic [NUM_HARTS-1:0] rack,
  output logic [NUM_HARTS-1:0] havereset
);
  for (genvar i = 0; i < NUM_HARTS; i++) begin : g_hart
    logic prev_rst;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pending[i]   <= 1'b0;
        rack[i]      <= 1'b0;
        havereset[i] <= 1'b1;
        prev_rst     <= 1'b0;
      end else begin
        prev_rst <= eff_rst[i];
        if (deact)
          pending[i] <= 1'b0;
        else if (resume_wr && wr_sel[i])
          pending[i] <= 1'b1;
        else if (resume_ack_i[i])
          pending[i] <= 1'b0;

        if (resume_wr && wr_sel[i])
          rack[i] <= 1'b0;
        else if (pending[i] && resume_ack_i[i])
          rack[i] <= 1'b1;

        if (prev_rst && !eff_rst[i])
          havereset[i] <= 1'b1;
        else if (ackhr_wr && wr_sel[i])
          havereset[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dbg_status_agg.sv
module dbg_status_agg #(
  parameter int NUM_HARTS = 4
) (
  input  logic [NUM_HARTS-1:0] sel,
  input  logic [NUM_HARTS-1:0] flag,
  output logic                 any_o,
  output logic                 all_o
);
  assign any_o = |(sel & flag);
  assign all_o = (|sel) & (&(flag | ~sel));
endmodule

// File: rtl/dbg_runctl.sv
module dbg_runctl
  import dbg_runctl_pkg::*;
#(
  parameter int NUM_HARTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [6:0]           reg_addr,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [NUM_HARTS-1:0] hart_mask_i,
  input  logic [NUM_HARTS-1:0] halted_i,
  input  logic [NUM_HARTS-1:0] running_i,
  input  logic [NUM_HARTS-1:0] resume_ack_i,
  output logic [NUM_HARTS-1:0] halt_req_o,
  output logic [NUM_HARTS-1:0] resume_req_o,
  output logic [NUM_HARTS-1:0] hart_reset_o,
  output logic                 sys_reset_o
);
  logic active_q;
  ctl_t ctl_q;

  logic ctl_wr, fld_ok, resume_wr, ackhr_wr, deact;
  assign ctl_wr    = reg_wr && (reg_addr == ADDR_CTRL);
  assign fld_ok    = ctl_wr && active_q && reg_wdata[C_ACTIVE];
  assign resume_wr = fld_ok && reg_wdata[C_RESUME] && !reg_wdata[C_HALT];
  assign ackhr_wr  = fld_ok && reg_wdata[C_ACKHR];
  assign deact     = ctl_wr && !reg_wdata[C_ACTIVE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      ctl_q    <= '0;
    end else if (ctl_wr) begin
      active_q <= reg_wdata[C_ACTIVE];
      if (fld_ok) begin
        ctl_q.halt   <= reg_wdata[C_HALT];
        ctl_q.hrst   <= reg_wdata[C_HRST];
        ctl_q.hasel  <= reg_wdata[C_HASEL];
        ctl_q.hsel   <= reg_wdata[C_SEL_LO +: SEL_W];
        ctl_q.sysrst <= reg_wdata[C_SYSRST];
      end else begin
        ctl_q <= '0;
      end
    end
  end

  // selection held in the register and selection carried by a write
  logic [NUM_HARTS-1:0] cur_sel, wr_sel;
  logic cur_beyond, wr_beyond;

  dbg_hart_sel #(.NUM_HARTS(NUM_HARTS)) u_sel_cur (
    .hartsel(ctl_q.hsel), .hasel(ctl_q.hasel), .mask(hart_mask_i),
    .sel(cur_sel), .beyond(cur_beyond)
  );

  dbg_hart_sel #(.NUM_HARTS(NUM_HARTS)) u_sel_wr (
    .hartsel(reg_wdata[C_SEL_LO +: SEL_W]), .hasel(reg_wdata[C_HASEL]),
    .mask(hart_mask_i), .sel(wr_sel), .beyond(wr_beyond)
  );

  logic [NUM_HARTS-1:0] eff_rst, rack, havereset;
  assign eff_rst      = ({NUM_HARTS{ctl_q.hrst}} & cur_sel) | {NUM_HARTS{ctl_q.sysrst}};
  assign halt_req_o   = {NUM_HARTS{ctl_q.halt}} & cur_sel;
  assign hart_reset_o = {NUM_HARTS{ctl_q.hrst}} & cur_sel;
  assign sys_reset_o  = ctl_q.sysrst;

  dbg_hart_track #(.NUM_HARTS(NUM_HARTS)) u_track (
    .clk(clk), .rst_n(rst_n), .resume_wr(resume_wr), .ackhr_wr(ackhr_wr),
    .deact(deact), .wr_sel(wr_sel), .eff_rst(eff_rst),
    .resume_ack_i(resume_ack_i), .pending(resume_req_o), .rack(rack),
    .havereset(havereset)
  );

  logic [NFLAG-1:0][NUM_HARTS-1:0] flags;
  logic [NFLAG-1:0] f_any, f_all;
  assign flags[F_HALTED] = halted_i;
  assign flags[F_RUN]    = running_i;
  assign flags[F_UNAV]   = eff_rst;
  assign flags[F_RACK]   = rack;
  assign flags[F_HRST]   = havereset;

  for (genvar k = 0; k < NFLAG; k++) begin : g_agg
    dbg_status_agg #(.NUM_HARTS(NUM_HARTS)) u_agg (
      .sel(cur_sel), .flag(flags[k]), .any_o(f_any[k]), .all_o(f_all[k])
    );
  end

  logic [31:0] stat_word, ctrl_word;
  always_comb begin
    stat_word        = '0;
    stat_word[3:0]   = SPEC_VER;
    stat_word[7]     = 1'b1;
    stat_word[9:8]   = {f_all[F_HALTED], f_any[F_HALTED]};
    stat_word[11:10] = {f_all[F_RUN],    f_any[F_RUN]};
    stat_word[13:12] = {f_all[F_UNAV],   f_any[F_UNAV]};
    stat_word[15:14] = {2{cur_beyond}};
    stat_word[17:16] = {f_all[F_RACK],   f_any[F_RACK]};
    stat_word[19:18] = {f_all[F_HRST],   f_any[F_HRST]};
    ctrl_word                        = '0;
    ctrl_word[C_HALT]                = ctl_q.halt;
    ctrl_word[C_HRST]                = ctl_q.hrst;
    ctrl_word[C_HASEL]               = ctl_q.hasel;
    ctrl_word[C_SEL_LO +: SEL_W]     = ctl_q.hsel;
    ctrl_word[C_SYSRST]              = ctl_q.sysrst;
    ctrl_word[C_ACTIVE]              = active_q;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (reg_addr == ADDR_CTRL)      reg_rdata = ctrl_word;
      else if (reg_addr == ADDR_STAT) reg_rdata = stat_word;
    end
  end

  logic [SEL_W-1:0] cur_hsel;
  logic cur_hasel;
  assign cur_hsel  = ctl_q.hsel;
  assign cur_hasel = ctl_q.hasel;

  logic unused_bits;
  assign unused_bits = ^{reg_wdata[27], reg_wdata[15:2], wr_beyond};
endmodule

// File: rtl/dbg_runctl_chk.sv
module dbg_runctl_chk
  import dbg_runctl_pkg::*;
#(
  parameter int NUM_HARTS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [6:0]           reg_addr,
  input logic                 reg_wr,
  input logic                 reg_rd,
  input logic [31:0]          reg_wdata,
  input logic [31:0]          reg_rdata,
  input logic [NUM_HARTS-1:0] resume_ack_i,
  input logic [NUM_HARTS-1:0] halt_req_o,
  input logic [NUM_HARTS-1:0] resume_req_o,
  input logic [NUM_HARTS-1:0] hart_reset_o,
  input logic                 sys_reset_o,
  input logic [SEL_W-1:0]     cur_hsel,
  input logic                 cur_hasel
);
  // R3
  deact_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_CTRL && !reg_wdata[C_ACTIVE]) |=>
    (halt_req_o == '0 && resume_req_o == '0 && hart_reset_o == '0 && !sys_reset_o));

  // R2
  version_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ADDR_STAT) |-> (reg_rdata[3:0] == SPEC_VER && !reg_rdata[22]));

  // R6
  resume_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && (resume_req_o & resume_ack_i) != '0) |=>
    ((resume_req_o & $past(resume_req_o & resume_ack_i)) == '0));

  // R9
  nonexist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ADDR_STAT && int'(cur_hsel) >= NUM_HARTS) |->
    (reg_rdata[15:14] == 2'b11));

  // R4
  single_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_hasel |-> $onehot0(halt_req_o));
endmodule

bind dbg_runctl dbg_runctl_chk #(.NUM_HARTS(NUM_HARTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .resume_ack_i(resume_ack_i), .halt_req_o(halt_req_o),
  .resume_req_o(resume_req_o), .hart_reset_o(hart_reset_o),
  .sys_reset_o(sys_reset_o), .cur_hsel(cur_hsel), .cur_hasel(cur_hasel)
);

// File: tb/dbg_runctl_test.sv
module dbg_runctl_test;
  localparam int PERIOD = 10;
  localparam int NH = 4;
  localparam logic [31:0] ACT = 32'h1, SYS = 32'h2, HALT = 32'h8000_0000,
    RES = 32'h4000_0000, HRST = 32'h2000_0000, ACKHR = 32'h1000_0000,
    HASEL = 32'h0400_0000;

  logic clk = 0, rst_n = 1;
  logic [6:0] reg_addr = 7'h11;
  logic reg_wr = 0, reg_rd = 1;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [NH-1:0] hart_mask_i = 0, halted_i = 0, running_i = 0, resume_ack_i = 0;
  logic [NH-1:0] halt_req_o, resume_req_o, hart_reset_o;
  logic sys_reset_o;

  int total = 0, bad = 0;
  bit live = 0, done = 0;

  dbg_runctl #(.NUM_HARTS(NH)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .hart_mask_i(hart_mask_i), .halted_i(halted_i), .running_i(running_i),
    .resume_ack_i(resume_ack_i), .halt_req_o(halt_req_o),
    .resume_req_o(resume_req_o), .hart_reset_o(hart_reset_o),
    .sys_reset_o(sys_reset_o)
  );

  always #(PERIOD/2) clk = ~clk;

  // behavioural model state
  bit m_act, m_ndm, m_halt, m_hrst, m_hasel;
  int m_hsel;
  bit [7:0] m_pend, m_ack, m_hr, m_prev;

  function automatic bit msel(int i, int hs, bit ha);
    return (hs == i) || (ha && hart_mask_i[i]);
  endfunction

  function automatic bit meff(int i);
    return (m_hrst && msel(i, m_hsel, m_hasel)) || m_ndm;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_ndm = 0; m_halt = 0; m_hrst = 0; m_hasel = 0; m_hsel = 0;
      m_pend = 0; m_ack = 0; m_prev = 0; m_hr = 0;
      for (int i = 0; i < NH; i++) m_hr[i] = 1;
    end else begin
      bit cw, ok, rw, aw, da, e, ws;
      bit [7:0] np, na, nh;
      int whs;
      np = m_pend; na = m_ack; nh = m_hr;
      cw = reg_wr && reg_addr == 7'h10;
      ok = cw && m_act && reg_wdata[0];
      rw = ok && reg_wdata[30] && !reg_wdata[31];
      aw = ok && reg_wdata[28];
      da = cw && !reg_wdata[0];
      whs = int'(reg_wdata[25:16]);
      for (int i = 0; i < NH; i++) begin
        e = meff(i);
        ws = msel(i, whs, reg_wdata[26]);
        if (aw && ws) nh[i] = 0;
        if (m_prev[i] && !e) nh[i] = 1;
        m_prev[i] = e;
        if (m_pend[i] && resume_ack_i[i]) begin np[i] = 0; na[i] = 1; end
        if (rw && ws) begin np[i] = 1; na[i] = 0; end
        if (da) np[i] = 0;
      end
      m_pend = np; m_ack = na; m_hr = nh;
      if (cw) begin
        m_act = reg_wdata[0];
        m_halt = ok && reg_wdata[31];
        m_hrst = ok && reg_wdata[29];
        m_hasel = ok && reg_wdata[26];
        m_hsel = ok ? whs : 0;
        m_ndm = ok && reg_wdata[1];
      end
    end
  end

  function automatic logic [1:0] agg(logic [NH-1:0] f);
    bit any_v = 0, all_v = 1, none = 1;
    for (int i = 0; i < NH; i++)
      if (msel(i, m_hsel, m_hasel)) begin
        none = 0;
        if (f[i]) any_v = 1; else all_v = 0;
      end
    return {all_v && !none, any_v};
  endfunction

  function automatic logic [31:0] exp_rdata();
    logic [31:0] w = 0;
    logic [NH-1:0] un, ak, hr;
    for (int i = 0; i < NH; i++) begin
      un[i] = meff(i); ak[i] = m_ack[i]; hr[i] = m_hr[i];
    end
    if (!reg_rd) return 0;
    if (reg_addr == 7'h10) begin
      w[31] = m_halt; w[29] = m_hrst; w[26] = m_hasel;
      w[25:16] = m_hsel[9:0]; w[1] = m_ndm; w[0] = m_act;
    end else if (reg_addr == 7'h11) begin
      w[3:0] = 4'd2; w[7] = 1;
      w[9:8] = agg(halted_i); w[11:10] = agg(running_i);
      w[13:12] = agg(un); w[15:14] = (m_hsel >= NH) ? 2'b11 : 2'b00;
      w[17:16] = agg(ak); w[19:18] = agg(hr);
    end
    return w;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && live && !done) begin
      logic [NH-1:0] eh, er;
      logic [31:0] ew;
      for (int i = 0; i < NH; i++) begin
        eh[i] = m_halt && msel(i, m_hsel, m_hasel);
        er[i] = m_hrst && msel(i, m_hsel, m_hasel);
      end
      chk("R4", 32'(halt_req_o), 32'(eh));
      chk("R5", 32'(hart_reset_o), 32'(er));
      chk("R5", 32'(sys_reset_o), 32'(m_ndm));
      chk("R6", 32'(resume_req_o), 32'(m_pend[NH-1:0]));
      ew = exp_rdata();
      if (reg_rd && reg_addr == 7'h11) begin
        chk("R2", reg_rdata & 32'hFFF0_00FF, ew & 32'hFFF0_00FF);
        chk("R8", 32'(reg_rdata[13:8]), 32'(ew[13:8]));
        chk("R9", 32'(reg_rdata[15:14]), 32'(ew[15:14]));
        chk("R6", 32'(reg_rdata[17:16]), 32'(ew[17:16]));
        chk("R10", 32'(reg_rdata[19:18]), 32'(ew[19:18]));
      end else if (reg_rd && reg_addr == 7'h10) begin
        chk(m_act ? "R11" : "R3", reg_rdata, ew);
      end else begin
        chk("R2", reg_rdata, ew);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [31:0] d);
    reg_addr = 7'h10; reg_wr = 1; reg_wdata = d;
    tick();
    reg_wr = 0; reg_addr = 7'h11;
  endtask

  task automatic peek();
    #2;
  endtask

  function automatic logic [31:0] sel(int n);
    return 32'(n) << 16;
  endfunction

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(PERIOD * 50000);
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    #2 rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1; live = 1;
    peek();
    // R1
    chk("R1", 32'(halt_req_o | resume_req_o | hart_reset_o), 0);
    chk("R1", 32'(sys_reset_o), 0);
    chk("R1", 32'(reg_rdata[19:18]), 32'b11);
    // R2
    chk("R2", 32'(reg_rdata[3:0]), 2);
    chk("R2", 32'({reg_rdata[22], reg_rdata[7]}), 32'b01);
    reg_addr = 7'h10; peek();
    chk("R1", reg_rdata, 0);
    reg_addr = 7'h12; peek();
    chk("R2", reg_rdata, 0);
    reg_addr = 7'h11; reg_rd = 0; peek();
    chk("R2", reg_rdata, 0);
    reg_rd = 1;
    tick();

    // R3: fields ignored while inactive
    wr(ACT | HALT | sel(2));
    peek();
    chk("R3", 32'(halt_req_o), 0);
    reg_addr = 7'h10; peek();
    chk("R3", reg_rdata, 32'h1);
    reg_addr = 7'h11;

    // R4: single and array selection
    wr(ACT | HALT | sel(2)); peek();
    chk("R4", 32'(halt_req_o), 32'b0100);
    hart_mask_i = 4'b1001;
    wr(ACT | HALT | HASEL | sel(2)); peek();
    chk("R4", 32'(halt_req_o), 32'b1101);
    // R8 summaries
    halted_i = 4'b1101; peek();
    chk("R8", 32'(reg_rdata[9:8]), 32'b11);
    halted_i = 4'b0100; running_i = 4'b0010; peek();
    chk("R8", 32'(reg_rdata[9:8]), 32'b01);
    chk("R8", 32'(reg_rdata[11:10]), 32'b00);
    tick();

    // R6: resume handshake
    hart_mask_i = 0;
    wr(ACT | sel(1));
    wr(ACT | RES | sel(1)); peek();
    chk("R6", 32'(resume_req_o), 32'b0010);
    chk("R6", 32'(reg_rdata[17:16]), 32'b00);
    tick();
    resume_ack_i = 4'b0010; tick(); resume_ack_i = 0; peek();
    chk("R6", 32'(resume_req_o), 0);
    chk("R6", 32'(reg_rdata[17:16]), 32'b11);

    // R7: resume write meets acknowledge
    wr(ACT | RES | sel(1));
    reg_addr = 7'h10; reg_wr = 1; reg_wdata = ACT | RES | sel(1);
    resume_ack_i = 4'b0010;
    tick();
    reg_wr = 0; reg_addr = 7'h11; resume_ack_i = 0; peek();
    chk("R7", 32'(resume_req_o), 32'b0010);
    chk("R7", 32'(reg_rdata[17:16]), 32'b00);
    resume_ack_i = 4'b0010; tick(); resume_ack_i = 0; peek();
    chk("R7", 32'(resume_req_o), 0);

    // R6: resume together with halt starts nothing
    wr(ACT | HALT | RES | sel(1)); peek();
    chk("R6", 32'(resume_req_o), 0);
    chk("R6", 32'(reg_rdata[17:16]), 32'b11);

    // R5 / R10: hart reset and have-reset
    wr(ACT | ACKHR | sel(3)); peek();
    chk("R10", 32'(reg_rdata[19:18]), 32'b00);
    wr(ACT | HRST | sel(3)); peek();
    chk("R5", 32'(hart_reset_o), 32'b1000);
    chk("R8", 32'(reg_rdata[13:12]), 32'b11);
    wr(ACT | sel(3)); peek();
    chk("R5", 32'(hart_reset_o), 0);
    chk("R10", 32'(reg_rdata[19:18]), 32'b00);
    tick(); peek();
    chk("R10", 32'(reg_rdata[19:18]), 32'b11);
    wr(ACT | ACKHR | sel(3)); peek();
    chk("R10", 32'(reg_rdata[19:18]), 32'b00);
    wr(ACT | HRST | sel(3));
    wr(ACT | sel(3));
    wr(ACT | ACKHR | sel(3)); peek();
    chk("R10", 32'(reg_rdata[19:18]), 32'b11);

    // R9: nonexistent selection
    wr(ACT | sel(5)); peek();
    chk("R9", 32'(reg_rdata[15:14]), 32'b11);
    wr(ACT | sel(3)); peek();
    chk("R9", 32'(reg_rdata[15:14]), 32'b00);

    // R5: system reset
    wr(ACT | SYS | sel(0)); peek();
    chk("R5", 32'(sys_reset_o), 1);

    // R11: control readback
    wr(ACT | HALT | HASEL | SYS | RES | ACKHR | sel(3));
    reg_addr = 7'h10; peek();
    chk("R11", reg_rdata, ACT | HALT | HASEL | SYS | sel(3));
    reg_addr = 7'h11;

    // R3: deactivation clears everything
    wr(ACT | RES | sel(0)); peek();
    chk("R3", 32'(resume_req_o), 32'b0001);
    wr(HALT | HRST | sel(0)); peek();
    chk("R3", 32'(halt_req_o | resume_req_o | hart_reset_o), 0);
    chk("R3", 32'(sys_reset_o), 0);
    repeat (3) tick();

    done = 1;
    summary();
    $finish;
  end
endmodule